// File: doc/BRIEF.md
# Two-Table Compressed Quarter-Sine Lookup

This block converts a quarter-wave phase index, spanning 0 to pi/2, into an unsigned sine magnitude without a full-size quarter-wave table. The index is cut into three equal fields: a coarse field `a`, a middle field `b` and a fine field `c`. The identity sin(x+y) = sin(x)cos(y) + cos(x)sin(y) is applied with the small-angle approximations cos(c) = 1 and cos(a+b) replaced by cos(a). The result becomes the sum of two lookups: a coarse table indexed by `{a,b}` that holds sin(a+b), and a correction table indexed by `{a,c}` that holds cos(a)·sin(c).

Both tables are filled at elaboration time from parameters. With the default 12-bit index and 16-bit output they hold 256×16 and 256×9 bits, against 4096×16 bits for a plain quarter-wave table. The sum is clamped at full scale, 2^OUT_W-1. A valid flag travels with the data through two register stages. While no valid data moves through, every stage holds its contents. The block sits behind a phase accumulator and a quadrant folder, which are not part of it.

Top module: `qsin_twotable`

## Requirements
- R1: The phase index splits into `a` = phase_i[11:8], `b` = phase_i[7:4] and `c` = phase_i[3:0]. The coarse table is addressed by phase_i[11:4] and the correction table by {phase_i[11:8], phase_i[3:0]}.
- R2: For a valid input p, mag_o is within 1 LSB of round(FS·(sin(π·(p>>4)/512) + cos(π·a/32)·sin(π·c/8192))), where FS = 65535. If that value is larger than FS, the bound applies to FS instead.
- R3: The adder saturates. mag_o never wraps below the coarse term. Phase 4095 gives exactly 65535.
- R4: valid_o equals valid_i delayed by exactly two clock cycles.
- R5: When valid_o is low, mag_o keeps the value it had on the last valid output, whatever phase_i does in the meantime.
- R6: While rst_i (synchronous, active high) is asserted, valid_o and mag_o are 0 from the next clock edge on.
- R7: Every valid output is within 40 LSB of FS·sin(π·p/8192), the exact quarter sine for that phase.
- R8: When `c` = 0 the correction term is zero. Phase 0 gives exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Phase index on phase_i is valid |
| phase_i | input | 12 | Quarter-wave phase index, 0 to pi/2 |
| valid_o | output | 1 | mag_o holds a new result |
| mag_o | output | 16 | Unsigned sine magnitude, full scale 65535 |

## Verification
The bench builds the block with its default parameters: 4-bit fields and a 16-bit output. This makes the whole 4096-entry phase space small enough to sweep completely in a few thousand cycles. The sweep reaches the saturating corner near pi/2, the zero-correction entries where `c` is 0, and the worst approximation error where `b` and `c` are both large. A second pass walks a scattered phase order with regular bubbles in valid_i, to exercise the hold behaviour and the valid delay, and a reset in mid-stream checks that the pipeline clears.

// File: rtl/qsin_pkg.sv
package qsin_pkg;

   localparam real QS_PI = 3.14159265358979323846;

   // Odd Taylor series; terms up to x^15 keep the error far below one LSB on [0, pi/2]
   function automatic real qs_sin(input real x);
      real term;
      real acc;
      term = x;
      acc  = x;
      for (int k = 1; k < 8; k++) begin
         term = -term * x * x / real'((2 * k) * (2 * k + 1));
         acc  = acc + term;
      end
      return acc;
   endfunction

   function automatic real qs_cos(input real x);
      return qs_sin(QS_PI / 2.0 - x);
   endfunction

   function automatic real qs_fullscale(input int out_w);
      return real'((longint'(1) << out_w) - 1);
   endfunction

   // Coarse table entry: sin of an index with ab_w bits across a quarter turn
   function automatic int coarse_entry(input int idx, input int ab_w, input int out_w);
      real ang;
      ang = real'(idx) * (QS_PI / 2.0) / real'(longint'(1) << ab_w);
      return $rtoi(qs_fullscale(out_w) * qs_sin(ang) + 0.5);
   endfunction

   // Correction entry: cos(a)*sin(c), with the same LSB weight as the coarse entry
   function automatic int fine_entry(input int a, input int c, input int fld_w, input int out_w);
      real ang_a;
      real ang_c;
      ang_a = real'(a) * (QS_PI / 2.0) / real'(longint'(1) << fld_w);
      ang_c = real'(c) * (QS_PI / 2.0) / real'(longint'(1) << (3 * fld_w));
      return $rtoi(qs_fullscale(out_w) * qs_cos(ang_a) * qs_sin(ang_c) + 0.5);
   endfunction

endpackage

// File: rtl/qsin_coarse_rom.sv
module qsin_coarse_rom #(
   parameter int FIELD_W = 4,
   parameter int OUT_W   = 16,
   localparam int AB_W   = 2 * FIELD_W,
   localparam int DEPTH  = 1 << AB_W
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   input  logic [AB_W-1:0]  addr_i,
   output logic [OUT_W-1:0] q_o
);

   logic [OUT_W-1:0] tbl_w [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      localparam int VAL = qsin_pkg::coarse_entry(gi, AB_W, OUT_W);
      assign tbl_w[gi] = OUT_W'(VAL);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)     q_o <= '0;
      else if (en_i) q_o <= tbl_w[addr_i];
   end

endmodule

// File: rtl/qsin_fine_rom.sv
module qsin_fine_rom #(
   parameter int FIELD_W = 4,
   parameter int OUT_W   = 16,
   parameter int FINE_W  = 9,
   localparam int AC_W   = 2 * FIELD_W,
   localparam int DEPTH  = 1 << AC_W,
   localparam int C_MAX  = (1 << FIELD_W) - 1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic [AC_W-1:0]   addr_i,
   output logic [FINE_W-1:0] q_o
);

   // Largest correction sits at a = 0, c = all ones; it must fit the table width
   localparam int PEAK = qsin_pkg::fine_entry(0, C_MAX, FIELD_W, OUT_W);
   if (PEAK >= (1 << FINE_W)) begin : g_chk_width
      $error("qsin_fine_rom: FINE_W too narrow for the correction term");
   end

   logic [FINE_W-1:0] tbl_w [DEPTH];

   for (genvar ga = 0; ga <= C_MAX; ga++) begin : g_a
      for (genvar gc = 0; gc <= C_MAX; gc++) begin : g_c
         localparam int VAL = qsin_pkg::fine_entry(ga, gc, FIELD_W, OUT_W);
         assign tbl_w[(ga << FIELD_W) | gc] = FINE_W'(VAL);
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)     q_o <= '0;
      else if (en_i) q_o <= tbl_w[addr_i];
   end

   AST_FINE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && addr_i[FIELD_W-1:0] == '0) |=> (q_o == '0)); // R8

endmodule

// File: rtl/qsin_sum_sat.sv
module qsin_sum_sat #(
   parameter int OUT_W  = 16,
   parameter int FINE_W = 9
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic [OUT_W-1:0]  coarse_i,
   input  logic [FINE_W-1:0] fine_i,
   output logic [OUT_W-1:0]  q_o
);

   localparam logic [OUT_W:0] FULL = {1'b0, {OUT_W{1'b1}}};

   logic [OUT_W:0]   sum_w;
   logic [OUT_W-1:0] clip_w;

   always_comb begin
      sum_w  = {1'b0, coarse_i} + (OUT_W + 1)'(fine_i);
      clip_w = (sum_w > FULL) ? FULL[OUT_W-1:0] : sum_w[OUT_W-1:0];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)     q_o <= '0;
      else if (en_i) q_o <= clip_w;
   end

   AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
      en_i |=> (q_o >= $past(coarse_i))); // R3

   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> $stable(q_o)); // R5

endmodule

// File: rtl/qsin_twotable.sv
module qsin_twotable #(
   parameter int FIELD_W  = 4,
   parameter int OUT_W    = 16,
   parameter int FINE_W   = 9,
   localparam int PHASE_W = 3 * FIELD_W,
   localparam int IDX_W   = 2 * FIELD_W
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               valid_i,
   input  logic [PHASE_W-1:0] phase_i,
   output logic               valid_o,
   output logic [OUT_W-1:0]   mag_o
);

   if (FIELD_W < 2 || FIELD_W > 6) begin : g_chk_field
      $error("qsin_twotable: FIELD_W must lie in 2..6");
   end
   if (OUT_W < 8 || OUT_W > 30) begin : g_chk_out
      $error("qsin_twotable: OUT_W must lie in 8..30");
   end
   if (FINE_W < 1 || FINE_W >= OUT_W) begin : g_chk_fine
      $error("qsin_twotable: FINE_W must be narrower than OUT_W");
   end

   logic [FIELD_W-1:0] fld_a_w;
   logic [FIELD_W-1:0] fld_b_w;
   logic [FIELD_W-1:0] fld_c_w;
   logic [IDX_W-1:0]   ab_addr_w;
   logic [IDX_W-1:0]   ac_addr_w;

   assign fld_a_w   = phase_i[PHASE_W-1 -: FIELD_W];
   assign fld_b_w   = phase_i[2*FIELD_W-1 -: FIELD_W];
   assign fld_c_w   = phase_i[FIELD_W-1:0];
   assign ab_addr_w = {fld_a_w, fld_b_w};
   assign ac_addr_w = {fld_a_w, fld_c_w};

   logic [OUT_W-1:0]  coarse_q;
   logic [FINE_W-1:0] fine_q;
   logic              vld_mid_q;

   qsin_coarse_rom #(
      .FIELD_W (FIELD_W),
      .OUT_W   (OUT_W)
   ) u_coarse (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (valid_i),
      .addr_i (ab_addr_w),
      .q_o    (coarse_q)
   );

   qsin_fine_rom #(
      .FIELD_W (FIELD_W),
      .OUT_W   (OUT_W),
      .FINE_W  (FINE_W)
   ) u_fine (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (valid_i),
      .addr_i (ac_addr_w),
      .q_o    (fine_q)
   );

   qsin_sum_sat #(
      .OUT_W  (OUT_W),
      .FINE_W (FINE_W)
   ) u_sum (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (vld_mid_q),
      .coarse_i (coarse_q),
      .fine_i   (fine_q),
      .q_o      (mag_o)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         vld_mid_q <= 1'b0;
         valid_o   <= 1'b0;
      end else begin
         vld_mid_q <= valid_i;
         valid_o   <= vld_mid_q;
      end
   end

   AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_i |-> ##2 valid_o); // R4

   AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      !valid_i |-> ##2 !valid_o); // R4

   AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (!valid_i && !vld_mid_q) |=> ##1 $stable(mag_o)); // R5

endmodule

// File: tb/tb_qsin_twotable.sv
module tb_qsin_twotable;

   localparam int  CLK_PERIOD = 10;
   localparam int  FULL       = 65535;
   localparam real PI         = 3.14159265358979323846;

   logic        clk = 1'b0;
   logic        rst_i;
   logic        valid_i;
   logic [11:0] phase_i;
   logic        valid_o;
   logic [15:0] mag_o;

   int checks = 0;
   int fails  = 0;

   // Model of the two-cycle delay: d1 = last drive, d2 = the one before
   logic        v_d1 = 1'b0;
   logic        v_d2 = 1'b0;
   logic [11:0] p_d1 = '0;
   logic [11:0] p_d2 = '0;
   int          held = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   qsin_twotable dut (
      .clk_i   (clk),
      .rst_i   (rst_i),
      .valid_i (valid_i),
      .phase_i (phase_i),
      .valid_o (valid_o),
      .mag_o   (mag_o)
   );

   function automatic int model_mag(input int p);
      int  a;
      int  c;
      int  ab;
      real r;
      int  e;
      a  = p >> 8;
      c  = p & 15;
      ab = p >> 4;
      r  = real'(FULL) * ($sin(real'(ab) * PI / 512.0)
                        + $cos(real'(a) * PI / 32.0) * $sin(real'(c) * PI / 8192.0));
      e  = $rtoi(r + 0.5);
      if (e > FULL) e = FULL;
      return e;
   endfunction

   function automatic int absdiff(input int x, input int y);
      return (x > y) ? x - y : y - x;
   endfunction

   task automatic check(input bit ok, input string req, input int got, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d (time %0t)", req, got, exp, $time);
      end
   endtask

   task automatic step(input bit v, input int p);
      int  got;
      int  exp;
      real ideal;
      @(negedge clk);
      got = int'(mag_o);
      check(valid_o == v_d2, "R4 valid delay", int'(valid_o), int'(v_d2));
      if (v_d2) begin
         exp = model_mag(int'(p_d2));
         check(absdiff(got, exp) <= 1, "R1/R2 decomposed value", got, exp);
         ideal = real'(FULL) * $sin(real'(p_d2) * PI / 8192.0);
         check(absdiff(got, $rtoi(ideal + 0.5)) <= 40, "R7 true sine bound", got, $rtoi(ideal + 0.5));
         if (p_d2 == 12'd4095) check(got == FULL, "R3 saturation at top", got, FULL);
         if (p_d2 == 12'd0)    check(got == 0, "R8 zero phase", got, 0);
         held = got;
      end else begin
         check(got == held, "R5 hold while idle", got, held);
      end
      valid_i = v;
      phase_i = 12'(p);
      v_d2 = v_d1;
      p_d2 = p_d1;
      v_d1 = v;
      p_d1 = 12'(p);
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      rst_i   = 1'b1;
      valid_i = 1'b0;
      phase_i = 12'd4095;
      @(negedge clk);
      @(negedge clk);
      check(valid_o == 1'b0, "R6 reset valid", int'(valid_o), 0);
      check(mag_o == 16'd0, "R6 reset data", int'(mag_o), 0);
      rst_i = 1'b0;
      v_d1 = 1'b0;
      v_d2 = 1'b0;
      held = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst_i   = 1'b1;
      valid_i = 1'b0;
      phase_i = '0;
      repeat (3) @(negedge clk);
      check(valid_o == 1'b0, "R6 initial valid", int'(valid_o), 0);
      check(mag_o == 16'd0, "R6 initial data", int'(mag_o), 0);
      rst_i = 1'b0;

      // Full sweep with valid_i held high: every phase, R1 R2 R3 R7 R8
      for (int p = 0; p < 4096; p++) step(1'b1, p);
      step(1'b0, 0);
      step(1'b0, 0);

      // Scattered order with bubbles; phase moves during bubbles (R5)
      for (int i = 0; i < 4096; i++) begin
         if (i % 3 == 0) step(1'b0, (i * 1111) % 4096);
         else            step(1'b1, (i * 37 + 5) % 4096);
      end

      // Long idle run with a busy phase bus: output must not move (R5)
      for (int i = 0; i < 20; i++) step(1'b0, 4095 - i * 100);

      // Mid-stream reset, then resume (R6)
      step(1'b1, 2000);
      step(1'b1, 3000);
      pulse_reset();
      step(1'b1, 4095);
      step(1'b1, 0);
      step(1'b1, 16);
      step(1'b0, 1);
      step(1'b0, 2);
      step(1'b0, 3);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule